// File: doc/BRIEF.md
# Interrupt Factor Status Register

This block holds the interrupt factors that a disc-controller core reports to its host processor. It is one 16-bit word. Internal engines raise individual factor bits through one-cycle set strobes, and the host reads the word through a small synchronous register port. The host acknowledges a factor by writing the word back. Only the bits it writes as zero are cleared, so an acknowledge of one factor cannot disturb the others. A single registered IRQ line goes to the host. It is high while any factor bit is set.

There are fourteen factor bits, numbered from bit 0 upward:

- 0: command ready
- 1: data ready
- 2: one sector complete
- 3: buffer full
- 4: playback end
- 5: disc change
- 6: selector/soft-reset done
- 7: host I/O done
- 8: buffer copy/move done
- 9: file-system done
- 10: subcode-Q updated
- 11: decoder processing done
- 12: decoder interval end
- 13: decoder event

Bits 6, 7, 8, 9 and 11 form the command-end group. Bits 14 and 15 are reserved.

The block has two resets. The hard reset restores the full power-on pattern. The soft reset reloads every bit except disc-change, which keeps its value so that a media swap is not lost.

Top module: `irqfac_status`

## Requirements
- R1: Bits 15 and 14 of the register always read as 0. Factor bits occupy positions 13 down to 0, and `set_stb[i]` drives bit i.
- R2: While `rst` is high at a clock edge, the register loads 16'h0BE1: bits 0, 5, 6, 7, 8, 9 and 11 set, all others clear. `irq` is then 1.
- R3: A `soft_rst` pulse with `rst` low loads 16'h0BC1 into every bit except bit 5. Bit 5 keeps its value, or follows its own set or clear in that cycle.
- R4: When `cs` and `we` are both high, each factor bit whose `wdata` bit is 0 is cleared and each bit whose `wdata` bit is 1 is unchanged. With `cs` low, a write has no effect.
- R5: A high `set_stb[i]` sets bit i at the next edge. When a set and a host clear of the same bit fall in one cycle, the set wins.
- R6: During a soft reset, the soft-reset value takes priority over set strobes and host clears on every bit except bit 5.
- R7: A read (`cs` high, `we` low) places the register value held at that clock edge on `rdata` after the edge. `rdata` keeps that value until the next read, and a read changes no bit.
- R8: `irq` is a register that holds the OR of all factor bits as they stood at the previous edge. It falls one cycle after the last set bit is cleared and rises one cycle after a bit is set.
- R9: Hard reset takes priority over a simultaneous soft reset and returns bit 5 to 1 even if it was cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, one-cycle pulse, active high |
| set_stb | input | 14 | Per-factor set strobes, bit i sets factor i |
| cs | input | 1 | Register port select |
| we | input | 1 | Write enable (1 write, 0 read) |
| wdata | input | 16 | Write data; a 0 bit clears that factor |
| rdata | output | 16 | Read data, updated by read cycles |
| irq | output | 1 | Registered interrupt request to the host |

## Verification
The bench builds the block with its default parameters: fourteen factor bits in a 16-bit word, the 0BE1h/0BC1h reset patterns, and a keep mask that holds only bit 5. With these values the bench can drive all fourteen strobes at once next to two reserved bits, and can reach the case where a soft reset and a set, or a soft reset and a clear, land on the kept bit and on the reloaded bits in the same cycle. The vector walk runs each stimulus through the write-to-clear, set-wins and soft-reset cases and reads the word back after each one. Directed steps then cover the hard-reset state, the one-cycle IRQ latency and the behaviour of `rdata` between reads.

// File: rtl/irqfac_pkg.sv
package irqfac_pkg;
  localparam int unsigned REG_W       = 16;
  localparam int unsigned NUM_FACTORS = 14;

  // factor bit positions
  localparam int unsigned F_CMD_READY   = 0;
  localparam int unsigned F_DATA_READY  = 1;
  localparam int unsigned F_SECTOR_DONE = 2;
  localparam int unsigned F_BUF_FULL    = 3;
  localparam int unsigned F_PLAY_END    = 4;
  localparam int unsigned F_DISC_CHANGE = 5;
  localparam int unsigned F_SEL_DONE    = 6;
  localparam int unsigned F_HOST_DONE   = 7;
  localparam int unsigned F_COPY_DONE   = 8;
  localparam int unsigned F_FS_DONE     = 9;
  localparam int unsigned F_SUBQ_UPD    = 10;
  localparam int unsigned F_DEC_DONE    = 11;
  localparam int unsigned F_DEC_IVAL    = 12;
  localparam int unsigned F_DEC_EVENT   = 13;

  localparam logic [REG_W-1:0] CMD_END_GROUP =
      (REG_W'(1) << F_SEL_DONE) | (REG_W'(1) << F_HOST_DONE) |
      (REG_W'(1) << F_COPY_DONE) | (REG_W'(1) << F_FS_DONE) |
      (REG_W'(1) << F_DEC_DONE);

  localparam logic [REG_W-1:0] SOFT_PATTERN = CMD_END_GROUP | (REG_W'(1) << F_CMD_READY);
  localparam logic [REG_W-1:0] KEEP_PATTERN = REG_W'(1) << F_DISC_CHANGE;
  localparam logic [REG_W-1:0] HARD_PATTERN = SOFT_PATTERN | KEEP_PATTERN;
endpackage

// File: rtl/irqfac_cell.sv
module irqfac_cell #(
  parameter logic HARD_VAL = 1'b0,
  parameter logic SOFT_VAL = 1'b0,
  parameter logic KEEP     = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic soft_load;
  assign soft_load = soft_rst && !KEEP;

  always_ff @(posedge clk) begin
    if (rst)            q <= HARD_VAL;
    else if (soft_load) q <= SOFT_VAL;
    else if (set_i)     q <= 1'b1;
    else if (clr_i)     q <= 1'b0;
  end

  // R5: a set strobe outside a reloading soft reset always leaves the bit at 1
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (set_i && !soft_load) |=> q);

  // R4: outside set and soft reset a clear bit never rises (host writes only clear)
  assert_no_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !soft_load && !q) |=> !q);
endmodule

// File: rtl/irqfac_irq.sv
module irqfac_irq #(
  parameter int unsigned W       = 16,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] vec,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= RST_VAL;
    else     irq <= |vec;
  end

  // R8: irq follows the OR of the factors one cycle late
  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|vec)));
endmodule

// File: rtl/irqfac_rdport.sv
module irqfac_rdport #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic [W-1:0] value,
  output logic [W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= value;
  end

  // R7: rdata holds between reads
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/irqfac_status.sv
module irqfac_status
  import irqfac_pkg::*;
#(
  parameter int unsigned     W         = REG_W,
  parameter int unsigned     NF        = NUM_FACTORS,
  parameter logic [W-1:0]    HARD_INIT = HARD_PATTERN,
  parameter logic [W-1:0]    SOFT_INIT = SOFT_PATTERN,
  parameter logic [W-1:0]    KEEP_MASK = KEEP_PATTERN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic [NF-1:0] set_stb,
  input  logic          cs,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          irq
);
  localparam logic [W-1:0] FACTOR_MASK = (W'(1) << NF) - W'(1);
  localparam logic         IRQ_INIT    = |(HARD_INIT & FACTOR_MASK);

  logic [W-1:0] status;
  logic         wr_en;
  logic         rd_en;

  assign wr_en = cs && we;
  assign rd_en = cs && !we;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < NF) begin : g_factor
      irqfac_cell #(
        .HARD_VAL (HARD_INIT[i]),
        .SOFT_VAL (SOFT_INIT[i]),
        .KEEP     (KEEP_MASK[i])
      ) u_cell (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .set_i    (set_stb[i]),
        .clr_i    (wr_en && !wdata[i]),
        .q        (status[i])
      );
    end else begin : g_reserved
      assign status[i] = 1'b0;
    end
  end

  irqfac_irq #(.W(W), .RST_VAL(IRQ_INIT)) u_irq (
    .clk (clk),
    .rst (rst),
    .vec (status),
    .irq (irq)
  );

  irqfac_rdport #(.W(W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .value (status),
    .rdata (rdata)
  );

  // R1: reserved bits never read as 1
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~FACTOR_MASK) == '0);

  // R3: a soft reset reloads every non-kept bit
  assert_soft_load_R3: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> ((status & ~KEEP_MASK) == (SOFT_INIT & FACTOR_MASK & ~KEEP_MASK)));

  // R4: a write with the port deselected or a read changes no bit absent set/soft reset
  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !soft_rst && set_stb == '0) |=> $stable(status));
endmodule

// File: tb/sim_irqfac_status.sv
module sim_irqfac_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic [13:0] set_stb = '0;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  irqfac_status u0 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .set_stb(set_stb),
    .cs(cs), .we(we), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {soft, cs, we, set[13:0], wdata[15:0], expected[15:0]}
  localparam int NV = 13;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 14'h0000, 16'h0000, 16'h0000}, // R4 clear all
    {1'b0, 1'b0, 1'b0, 14'h0002, 16'h0000, 16'h0002}, // R5 single set
    {1'b0, 1'b0, 1'b0, 14'h3FFF, 16'h0000, 16'h3FFF}, // R1 R5 all strobes
    {1'b0, 1'b1, 1'b1, 14'h0000, 16'hFFFE, 16'h3FFE}, // R4 clear bit 0
    {1'b0, 1'b1, 1'b1, 14'h0100, 16'h00FF, 16'h01FE}, // R5 set beats clear
    {1'b1, 1'b0, 1'b0, 14'h0000, 16'h0000, 16'h0BE1}, // R3 soft keeps bit5=1
    {1'b0, 1'b1, 1'b1, 14'h0000, 16'hFFDF, 16'h0BC1}, // R4 clear bit5
    {1'b1, 1'b0, 1'b0, 14'h0000, 16'h0000, 16'h0BC1}, // R3 soft keeps bit5=0
    {1'b0, 1'b1, 1'b1, 14'h0020, 16'h0000, 16'h0020}, // R5 bit5 set wins
    {1'b1, 1'b0, 1'b0, 14'h0004, 16'h0000, 16'h0BE1}, // R6 soft beats set
    {1'b0, 1'b1, 1'b1, 14'h0000, 16'hFFFF, 16'h0BE1}, // R4 ones keep
    {1'b0, 1'b0, 1'b1, 14'h0000, 16'h0000, 16'h0BE1}, // R4 deselected write
    {1'b1, 1'b1, 1'b1, 14'h0000, 16'h0000, 16'h0BC1}  // R6 soft beats clear, bit5 cleared
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    soft_rst = 1'b0; set_stb = '0; cs = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic do_read();
    @(negedge clk);
    idle();
    cs = 1'b1; we = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    idle();
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R2 irq at reset", {15'b0, irq}, 16'h0001);
    @(negedge clk);
    rst = 1'b0;
    do_read();
    check("R2 reset value", rdata, 16'h0BE1);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      soft_rst = VEC[k][48];
      cs       = VEC[k][47];
      we       = VEC[k][46];
      set_stb  = VEC[k][45:32];
      wdata    = VEC[k][31:16];
      @(posedge clk); #1;
      do_read();
      check($sformatf("R1-vec%0d rdata", k), rdata, VEC[k][15:0]);
      check($sformatf("R8 vec%0d irq", k), {15'b0, irq}, {15'b0, |VEC[k][15:0]});
    end

    // R7: a write does not update rdata; rdata still shows the last read
    @(negedge clk);
    cs = 1'b1; we = 1'b1; wdata = 16'h0000;
    @(posedge clk); #1;
    check("R7 rdata holds", rdata, 16'h0BC1);
    // R8: the clear happened at that edge; irq still high, then falls
    check("R8 irq one cycle late", {15'b0, irq}, 16'h0001);
    @(negedge clk); idle();
    @(posedge clk); #1;
    check("R8 irq falls", {15'b0, irq}, 16'h0000);
    // R8 rise
    @(negedge clk); set_stb = 14'h0008;
    @(posedge clk); #1;
    check("R8 irq not yet up", {15'b0, irq}, 16'h0000);
    @(negedge clk); idle();
    @(posedge clk); #1;
    check("R8 irq rises", {15'b0, irq}, 16'h0001);
    do_read();
    check("R7 read value", rdata, 16'h0008);

    // R9: hard and soft reset together, bit5 was 0
    @(negedge clk);
    rst = 1'b1; soft_rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0; idle();
    do_read();
    check("R9 hard over soft", rdata, 16'h0BE1);
    check("R1 reserved bits", rdata & 16'hC000, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule